// File: doc/BRIEF.md
# Bus Fault Monitor

The bus fault monitor sits beside a small processor system bus and watches every bus cycle from its start strobe to its final acknowledge. It notices three kinds of trouble: a bus-error input from a peripheral, an access to an unimplemented word inside an on-chip register block, and a missing acknowledge within a fixed number of clocks. When one of these happens it terminates the cycle and sends the fault to the right place. If the cycle belongs to a CPU read, the core gets a bus-error exception. If it belongs to a CPU write, the core gets a non-maskable interrupt and a sticky status bit is set. If it belongs to the on-chip DMA, that DMA channel is aborted. An external master sees only the termination.

A three-bit control register holds the timeout enable, the DMA abnormal-end interrupt enable and the sticky write-error flag. For a burst, the timeout window restarts at every acknowledge. The cycle therefore fails only if one gap between beats reaches the limit.

Top module: `busfault_monitor`

## Requirements
- R1: After reset all fault outputs are 0 and `ctl_q` reads 3'b000.
- R2: A cycle starts when `bus_start` is sampled high while no cycle is active. The start cycle is cycle 0. While the cycle is active, `bus_err_in` high in cycle k gives `cyc_abort` high for one clock in cycle k+1, and the cycle ends. Once the cycle has ended, `bus_err_in` has no effect.
- R3: A fault in a cycle owned by the CPU (`bus_master`=2'b00) with `bus_write`=0 pulses `cpu_berr_exc` together with `cyc_abort`.
- R4: A fault in a CPU cycle with `bus_write`=1 pulses `cpu_nmi` together with `cyc_abort`, and sets `ctl_q[0]` (write-error flag) at the same edge.
- R5: `ctl_q[0]` stays 1 until a control write (`ctl_wr`) with `ctl_wdata[0]`=1. A control write with bit 0 = 0 leaves it unchanged. A new write fault in the same clock as a clearing write leaves it set.
- R6: A fault in a DMA cycle (`bus_master`=2'b01) pulses `dma_abort` with `cyc_abort`. `dma_irq` pulses with them only when `ctl_q[2]` is 1.
- R7: With `ctl_q[1]`=0 (timeout disabled), a missing acknowledge never causes a fault.
- R8: With `ctl_q[1]`=1, if no `bus_ack` is seen in cycles 1 through 256, the fault is taken in cycle 256 and `cyc_abort` rises in cycle 257. An acknowledge in cycle 256 ends the cycle normally.
- R9: In a burst (`bus_burst`=1 at start), each acknowledge without `bus_last` restarts the 256-clock window. An acknowledge with `bus_last` ends the cycle.
- R10: Cycles of an external master (`bus_master`=2'b10 or 2'b11) are timed the same way. Their faults pulse only `cyc_abort`.
- R11: Word address bits [31:24]=8'hFF form the internal space. Within it, bits [23:8] select a register block and bits [7:2] give the word offset. Blocks 0 to 3 implement 8, 32, 4 and 16 words. Any offset at or above that count, and any block of 4 or more, is a hole. A hole faults in cycle 1 with the owner routing. An implemented offset does not fault.
- R12: An external master accessing any address whose bits [31:24] are 8'hFF faults in cycle 1.
- R13: If `bus_err_in` and `bus_ack` are both high in the same active cycle, the cycle is reported as faulted.
- R14: `cpu_berr_exc`, `cpu_nmi` and `dma_abort` are one clock wide, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Cycle start strobe |
| bus_ack | input | 1 | Acknowledge (one beat) |
| bus_last | input | 1 | Marks the final acknowledge of a burst |
| bus_write | input | 1 | 1 = write cycle |
| bus_burst | input | 1 | 1 = burst read cycle |
| bus_master | input | 2 | Owner: 00 CPU, 01 DMA, 1x external |
| bus_addr | input | 30 | Word address, byte address bits [31:2] |
| bus_err_in | input | 1 | Peripheral bus-error report |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | {dma irq enable, timeout enable, write-error clear} |
| ctl_q | output | 3 | {dma irq enable, timeout enable, write-error flag} |
| cyc_abort | output | 1 | Terminate current cycle with error |
| cpu_berr_exc | output | 1 | CPU bus-error exception strobe |
| cpu_nmi | output | 1 | CPU non-maskable interrupt strobe |
| dma_abort | output | 1 | DMA channel abnormal-end strobe |
| dma_irq | output | 1 | DMA abnormal-end interrupt strobe |

## Verification
Two pairs of events can fall in the same clock. The first is a bus error and a normal acknowledge in one active cycle. The bench provokes this by raising `bus_err_in` exactly on the acknowledge beat, for every owner, and expects the fault strobes one clock later in place of a normal end. The second is a fresh write fault and a software clear of the sticky flag at the same edge. The bench raises the error and the clearing write in one cycle and expects the flag to read 1 afterwards. All expected fault cycles, including the timeout cycle for each burst gap pattern, come from arithmetic on the stimulus.

// File: rtl/busfault_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus fault monitor.
// Assumes a two-bit master code: 00 CPU, 01 DMA, 1x external.
package busfault_pkg;

    typedef enum logic [1:0] {
        OWN_CPU_RD = 2'd0,
        OWN_CPU_WR = 2'd1,
        OWN_DMA    = 2'd2,
        OWN_EXT    = 2'd3
    } owner_e;

    localparam int CTL_WERR = 0;
    localparam int CTL_TOEN = 1;
    localparam int CTL_DIRQ = 2;
    localparam int CTL_W    = 3;

    // Map master code and direction to the party that receives a fault.
    function automatic owner_e classify_owner(input logic [1:0] mst, input logic wr);
        owner_e o;
        case (mst)
            2'b00:   o = wr ? OWN_CPU_WR : OWN_CPU_RD;
            2'b01:   o = OWN_DMA;
            default: o = OWN_EXT;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bf_hole_detect.sv
`timescale 1ns/1ps
// Register-hole decoder.
// Flags an access that falls in the internal space (top address byte all
// ones) and either comes from an external master or hits no implemented word.
// Assumes the word address layout: [AW-1:AW-8] space, [AW-9:BLK_LSB] block,
// [BLK_LSB-1:2] word offset. Purely combinational.
module bf_hole_detect #(
    parameter int AW        = 32,
    parameter int NUM_BLK   = 4,
    parameter int BLK_LSB   = 8,
    parameter logic [NUM_BLK*8-1:0] BLK_WORDS = {8'd16, 8'd4, 8'd32, 8'd8}
) (
    input  logic [AW-1:2] addr,
    input  logic          from_ext,
    output logic          hole
);
    localparam int BW   = AW - 8 - BLK_LSB;
    localparam int OW   = BLK_LSB - 2;
    localparam int CMPW = ((OW > 8) ? OW : 8) + 1;

    logic               internal;
    logic [BW-1:0]      blk;
    logic [OW-1:0]      off;
    logic [CMPW-1:0]    off_x;
    logic [NUM_BLK-1:0] hit;

    assign internal = (addr[AW-1:AW-8] == 8'hFF);
    assign blk      = addr[AW-9:BLK_LSB];
    assign off      = addr[BLK_LSB-1:2];
    assign off_x    = CMPW'(off);

    // One comparator per implemented register block.
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        logic [CMPW-1:0] words_x;
        assign words_x = CMPW'(BLK_WORDS[i*8 +: 8]);
        assign hit[i]  = (blk == BW'(i)) && (off_x < words_x);
    end

    // Hole when internal and not a valid CPU/DMA register hit.
    always_comb begin
        hole = internal && (from_ext || (hit == '0));
    end

endmodule

// File: rtl/bf_timeout.sv
`timescale 1ns/1ps
// Acknowledge timeout counter.
// Cleared on a cycle start or a beat acknowledge, counts while a cycle is
// active, saturates at the last value. Expiry is raised when the window
// of TO_CYCLES clocks is used up and timing is enabled.
module bf_timeout #(
    parameter int TO_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic en,
    output logic expired
);
    localparam int CW = (TO_CYCLES > 2) ? $clog2(TO_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count clocks since the last start or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr || !run)            cnt <= '0;
        else if (cnt != LAST)            cnt <= cnt + 1'b1;
    end

    assign expired = en && run && (cnt == LAST);

endmodule

// File: rtl/bf_ctrl_reg.sv
`timescale 1ns/1ps
// Control register: timeout enable, DMA abnormal-end interrupt enable and
// a sticky write-error flag cleared by writing 1. A set in the same clock
// as a clear wins.
module bf_ctrl_reg
    import busfault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              set_werr,
    output logic [CTL_W-1:0]  q
);
    // Enable bits: plain read/write fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q[CTL_TOEN] <= 1'b0;
            q[CTL_DIRQ] <= 1'b0;
        end else if (wr) begin
            q[CTL_TOEN] <= wdata[CTL_TOEN];
            q[CTL_DIRQ] <= wdata[CTL_DIRQ];
        end
    end

    // Sticky write-error flag: set by a fault, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                       q[CTL_WERR] <= 1'b0;
        else if (set_werr)                q[CTL_WERR] <= 1'b1;
        else if (wr && wdata[CTL_WERR])   q[CTL_WERR] <= 1'b0;
    end

endmodule

// File: rtl/bf_route.sv
`timescale 1ns/1ps
// Fault router: turns a fault on the current cycle into one-clock strobes
// for the owner of that cycle. All outputs are registered, so they appear
// the clock after the fault is detected.
module bf_route
    import busfault_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fault,
    input  owner_e owner,
    input  logic   dirq_en,
    output logic   abort_o,
    output logic   cpu_exc_o,
    output logic   nmi_o,
    output logic   dma_abort_o,
    output logic   dma_irq_o
);
    // Register the strobes for one clock per fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_o     <= 1'b0;
            cpu_exc_o   <= 1'b0;
            nmi_o       <= 1'b0;
            dma_abort_o <= 1'b0;
            dma_irq_o   <= 1'b0;
        end else begin
            abort_o     <= fault;
            cpu_exc_o   <= fault && (owner == OWN_CPU_RD);
            nmi_o       <= fault && (owner == OWN_CPU_WR);
            dma_abort_o <= fault && (owner == OWN_DMA);
            dma_irq_o   <= fault && (owner == OWN_DMA) && dirq_en;
        end
    end

endmodule

// File: rtl/busfault_monitor.sv
`timescale 1ns/1ps
// Bus fault monitor (top).
// Tracks one bus cycle at a time from start to final acknowledge, detects
// bus-error input, register holes and acknowledge timeouts, and routes the
// fault to the cycle's owner. Assumes a start is only accepted when no
// cycle is active and that acknowledges are counted from the clock after
// the start clock.
module busfault_monitor
    import busfault_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TO_CYCLES = 256,
    parameter int NUM_BLK   = 4,
    parameter int BLK_LSB   = 8,
    parameter logic [NUM_BLK*8-1:0] BLK_WORDS = {8'd16, 8'd4, 8'd32, 8'd8}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_ack,
    input  logic              bus_last,
    input  logic              bus_write,
    input  logic              bus_burst,
    input  logic [1:0]        bus_master,
    input  logic [AW-1:2]     bus_addr,
    input  logic              bus_err_in,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              cyc_abort,
    output logic              cpu_berr_exc,
    output logic              cpu_nmi,
    output logic              dma_abort,
    output logic              dma_irq
);
    logic   cyc_active;
    owner_e owner_q;
    logic   burst_q;
    logic   hole_q;
    logic   hole_now;
    logic   start_ok;
    logic   to_expired;
    logic   fault;
    logic   done_ok;

    assign start_ok = bus_start && !cyc_active;

    bf_hole_detect #(
        .AW(AW), .NUM_BLK(NUM_BLK), .BLK_LSB(BLK_LSB), .BLK_WORDS(BLK_WORDS)
    ) u_hole (
        .addr     (bus_addr),
        .from_ext (bus_master[1]),
        .hole     (hole_now)
    );

    bf_timeout #(.TO_CYCLES(TO_CYCLES)) u_to (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ok || (cyc_active && bus_ack)),
        .run     (cyc_active),
        .en      (ctl_q[CTL_TOEN]),
        .expired (to_expired)
    );

    // Fault sources; a bus error beats a same-clock acknowledge.
    always_comb begin
        fault   = cyc_active && (bus_err_in || hole_q || (to_expired && !bus_ack));
        done_ok = cyc_active && bus_ack && (!burst_q || bus_last) && !fault;
    end

    // Cycle tracker: capture owner and attributes at start, drop at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_active <= 1'b0;
            owner_q    <= OWN_CPU_RD;
            burst_q    <= 1'b0;
            hole_q     <= 1'b0;
        end else if (start_ok) begin
            cyc_active <= 1'b1;
            owner_q    <= classify_owner(bus_master, bus_write);
            burst_q    <= bus_burst;
            hole_q     <= hole_now;
        end else if (fault || done_ok) begin
            cyc_active <= 1'b0;
            hole_q     <= 1'b0;
        end
    end

    bf_ctrl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .set_werr (fault && (owner_q == OWN_CPU_WR)),
        .q        (ctl_q)
    );

    bf_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault       (fault),
        .owner       (owner_q),
        .dirq_en     (ctl_q[CTL_DIRQ]),
        .abort_o     (cyc_abort),
        .cpu_exc_o   (cpu_berr_exc),
        .nmi_o       (cpu_nmi),
        .dma_abort_o (dma_abort),
        .dma_irq_o   (dma_irq)
    );

endmodule

// File: rtl/busfault_monitor_chk.sv
`timescale 1ns/1ps
// Property checker for the bus fault monitor, attached by bind.
module busfault_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_active,
    input logic       bus_err_in,
    input logic       ctl_wr,
    input logic [2:0] ctl_wdata,
    input logic [2:0] ctl_q,
    input logic       cyc_abort,
    input logic       cpu_berr_exc,
    input logic       cpu_nmi,
    input logic       dma_abort,
    input logic       dma_irq
);
    assert_single_route_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_berr_exc, cpu_nmi, dma_abort}));

    assert_abort_one_wide_R14: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |=> !cyc_abort);

    assert_route_with_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_berr_exc || cpu_nmi || dma_abort) |-> cyc_abort);

    assert_nmi_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_nmi |-> ctl_q[0]);

    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && !(ctl_wr && ctl_wdata[0])) |=> ctl_q[0]);

    assert_dma_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> (dma_abort && $past(ctl_q[2])));

    assert_err_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && bus_err_in) |=> cyc_abort);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_active |=> !cyc_abort);

endmodule

bind busfault_monitor busfault_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_active   (cyc_active),
    .bus_err_in   (bus_err_in),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .ctl_q        (ctl_q),
    .cyc_abort    (cyc_abort),
    .cpu_berr_exc (cpu_berr_exc),
    .cpu_nmi      (cpu_nmi),
    .dma_abort    (dma_abort),
    .dma_irq      (dma_irq)
);

// File: tb/sim_busfault_monitor.sv
`timescale 1ns/1ps
module sim_busfault_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_ack = 1'b0, bus_last = 1'b0;
    logic        bus_write = 1'b0, bus_burst = 1'b0, bus_err_in = 1'b0;
    logic [1:0]  bus_master = 2'b00;
    logic [31:2] bus_addr = '0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_wdata = 3'b000;
    logic [2:0]  ctl_q;
    logic        cyc_abort, cpu_berr_exc, cpu_nmi, dma_abort, dma_irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;
    bit  to_en = 0;
    bit  dirq_en = 0;

    always #2.5 clk = ~clk;

    busfault_monitor u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_ack(bus_ack),
        .bus_last(bus_last), .bus_write(bus_write), .bus_burst(bus_burst),
        .bus_master(bus_master), .bus_addr(bus_addr), .bus_err_in(bus_err_in),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .cyc_abort(cyc_abort), .cpu_berr_exc(cpu_berr_exc), .cpu_nmi(cpu_nmi),
        .dma_abort(dma_abort), .dma_irq(dma_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int blk_words(input int b);
        case (b)
            0: return 8;
            1: return 32;
            2: return 4;
            3: return 16;
            default: return 0;
        endcase
    endfunction

    // R11/R12 hole model
    function automatic bit is_hole(input logic [1:0] mst, input logic [31:2] a);
        int blk = int'(a[23:8]);
        int off = int'(a[7:2]);
        if (a[31:24] != 8'hFF) return 0;
        if (mst[1]) return 1;
        return off >= blk_words(blk);
    endfunction

    // Called at a negedge; leaves the bench at a negedge.
    task automatic ctl_write(input logic [2:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [1:0] mst, input logic wr,
                            input logic burst, input logic [31:2] a, input int nbeats,
                            input int g1, input int g, input int berr_at, input int wclr_at);
        int endc, ft, fb, f, stop;
        logic [4:0] route, exp, act;
        ctl_write({dirq_en, to_en, 1'b1});
        endc = g1 + (nbeats - 1) * g;
        f = 0;
        if (is_hole(mst, a)) f = 1;
        else begin
            ft = 0;
            if (to_en) begin
                if (g1 > 256) ft = 256;
                else if (nbeats > 1 && g > 256) ft = g1 + 256;
            end
            fb = (berr_at > 0 && berr_at <= endc) ? berr_at : 0;
            if (fb != 0 && (ft == 0 || fb <= ft)) f = fb;
            else f = ft;
        end
        route = {1'b1, (mst == 2'b00) && !wr, (mst == 2'b00) && wr,
                 mst == 2'b01, (mst == 2'b01) && dirq_en};
        bus_start = 1'b1; bus_master = mst; bus_write = wr; bus_burst = burst; bus_addr = a;
        @(negedge clk);
        bus_start = 1'b0;
        stop = ((f != 0) ? f : endc) + 3;
        for (int i = 1; i <= stop; i++) begin
            bit ackd;
            exp = (f != 0 && i - 1 == f) ? route : 5'b0;
            act = {cyc_abort, cpu_berr_exc, cpu_nmi, dma_abort, dma_irq};
            chk(tag, 32'(act), 32'(exp));
            ackd = (i == g1) || (nbeats > 1 && i > g1 && (i - g1) % g == 0 && (i - g1) / g < nbeats);
            bus_ack    = ackd;
            bus_last   = burst && ackd && (i == endc);
            bus_err_in = (i == berr_at);
            ctl_wr     = (i == wclr_at);
            ctl_wdata  = {dirq_en, to_en, 1'b1};
            @(negedge clk);
        end
        bus_ack = 1'b0; bus_last = 1'b0; bus_err_in = 1'b0; ctl_wr = 1'b0;
        // R4: write-error flag after the case
        chk({tag, " R4 flag"}, 32'(ctl_q[0]), 32'(f != 0 && mst == 2'b00 && wr));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes", 32'({cyc_abort, cpu_berr_exc, cpu_nmi, dma_abort, dma_irq}), 0);
        chk("R1 ctl", 32'(ctl_q), 0);

        // R7 R8 R10 R3 R4 R6: no acknowledge until 258
        for (int m = 0; m < 3; m++)
            for (int w = 0; w < 2; w++)
                for (int t = 0; t < 2; t++)
                    for (int d = 0; d < 2; d++) begin
                        to_en = t[0]; dirq_en = d[0];
                        run_case("R7/R8/R10 timeout sweep", 2'(m), w[0], 1'b0,
                                 30'h0400_0000, 1, 258, 1, 0, 0);
                        chk("R6 dirq bit", 32'(ctl_q[2]), 32'(dirq_en));
                    end

        // R8 boundary: ack in cycle 256 passes, 257 times out
        to_en = 1; dirq_en = 1;
        run_case("R8 ack at 256", 2'b01, 1'b0, 1'b0, 30'h0400_0001, 1, 256, 1, 0, 0);
        run_case("R8 ack at 257", 2'b01, 1'b0, 1'b0, 30'h0400_0001, 1, 257, 1, 0, 0);

        // R2 R13: bus error before, on and after the acknowledge beat
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int b = 1; b <= 4; b++)
                    run_case("R2/R13 berr sweep", 2'(m), w[0], 1'b0,
                             30'h0100_0010, 1, 3, 1, b, 0);

        // R9 burst window restart
        run_case("R9 burst 3x200", 2'b01, 1'b0, 1'b1, 30'h0200_0000, 3, 200, 200, 0, 0);
        run_case("R9 burst 2x256", 2'b00, 1'b0, 1'b1, 30'h0200_0000, 2, 256, 256, 0, 0);
        run_case("R9 burst gap 257", 2'b00, 1'b0, 1'b1, 30'h0200_0000, 2, 100, 257, 0, 0);
        run_case("R9 burst first 257", 2'b10, 1'b0, 1'b1, 30'h0200_0000, 2, 257, 10, 0, 0);
        run_case("R9 burst berr beat2", 2'b00, 1'b0, 1'b1, 30'h0200_0000, 3, 5, 5, 10, 0);

        // R11 R12 hole sweep around each block boundary
        to_en = 0;
        for (int blk = 0; blk <= 4; blk++)
            for (int k = 0; k < 2; k++)
                for (int m = 0; m < 3; m++)
                    for (int w = 0; w < 2; w++) begin
                        int off = (blk == 4) ? k : blk_words(blk) - 1 + k;
                        logic [31:2] a = {8'hFF, 16'(blk), 6'(off)};
                        run_case("R11/R12 hole sweep", 2'(m), w[0], 1'b0, a, 1, 3, 1, 0, 0);
                    end

        // R5: fault and clear in the same clock, then write-0 and write-1
        run_case("R5 set beats clear", 2'b00, 1'b1, 1'b0, 30'h0000_0100, 1, 3, 1, 1, 1);
        ctl_write({dirq_en, to_en, 1'b0});
        chk("R5 write 0 keeps flag", 32'(ctl_q[0]), 1);
        ctl_write({dirq_en, to_en, 1'b1});
        chk("R5 write 1 clears flag", 32'(ctl_q[0]), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule